// File: doc/BRIEF.md
# Display Frame Format Decoder

This block turns a snapshot of the display size, mode and configuration registers into a frame descriptor that a scanout engine can use. A single-cycle present strobe captures the register values. From them the block works out the row stride in bytes, the horizontal and vertical resolution, the pixel format code and the framebuffer base. It also reports whether output is enabled, whether a blank border-coloured frame must be shown instead of framebuffer contents, and whether the frame format differs from the one recorded in the alternate descriptor slot.

Two descriptor slots are used in turn, one per enabled present. Each enabled present compares its resolution and format with the slot it switches to, then stores itself in the slot it leaves. A present with output disabled sends the slot pointer back to slot 0 and clears slot 0's resolutions. All outputs are registered on the strobe edge and hold until the next strobe. A done pulse marks the cycle in which the new values are visible.

Top module: `dispfmt_decoder`

## Requirements
- R1: While rst_ni is low, and until the first present after it, every output is zero.
- R2: With the size register split into a 10-bit modulo (bits 29:20), lines-minus-one (bits 19:10) and words-minus-one (bits 9:0), stride_o equals (words + modulo - 1) * 4, where words = bits 9:0 + 1.
- R3: en_o after a present equals mode_i bit 0 AND cfg_i bit 0 as sampled on that present.
- R4: vres_o equals lines (bits 19:10 + 1), doubled when cfg_i bit 1 (interlace) is set.
- R5: fmt_o equals mode_i bits 3:2. hres_o is words*2 for codes 0 and 1, floor(words*4/3) for code 2, and words for code 3.
- R6: Outputs change only on the clock edge where present_i is high. done_o is high in exactly the cycle after each such edge.
- R7: On an enabled present, fmt_changed_o is set when hres, vres or format differs from the alternate slot (the slot the pointer switches to). The pointer starts at slot 0 and both slots reset to zero.
- R8: On a disabled present, en_o, fmt_changed_o and blank_o become 0, while stride_o, hres_o, vres_o, fmt_o, base_o and fill_o hold their values. The slot pointer returns to slot 0, so the next enabled present compares against slot 1.
- R9: On an enabled present, blank_o takes cfg2_i bit 3, and fill_o and base_o take border_i and base_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| present_i | input | 1 | Frame-present strobe |
| size_i | input | 32 | Size register: modulo, lines-1, words-1 |
| mode_i | input | 32 | Mode register: bit 0 enable, bits 3:2 format |
| cfg_i | input | 32 | Config register: bit 0 video out, bit 1 interlace |
| cfg2_i | input | 32 | Second config register: bit 3 blank |
| border_i | input | 32 | Border colour |
| base_i | input | 32 | Framebuffer base address |
| done_o | output | 1 | Pulse one cycle after a present |
| en_o | output | 1 | Output enabled |
| blank_o | output | 1 | Show a border-coloured blank frame |
| fill_o | output | 32 | Blank-frame colour |
| fmt_changed_o | output | 1 | Format differs from the alternate slot |
| fmt_o | output | 2 | Pixel format code |
| hres_o | output | 12 | Horizontal resolution in pixels |
| vres_o | output | 12 | Vertical resolution in lines |
| stride_o | output | 14 | Row stride in bytes |
| base_o | output | 32 | Framebuffer base address |

## Verification
The format-change detector and the blank selector act on the same enabled present. A present can therefore raise fmt_changed_o and blank_o together, and a disabled present must clear both at once. The bench drives presents that switch format while blank is set, and disabled presents placed between format changes. These include a sequence where only the slot-pointer reset decides the value of the change flag. A behavioural model with its own two-entry slot history compares every output on every clock, so each coincidence is judged field by field.

// File: rtl/dispfmt_pkg.sv
package dispfmt_pkg;
  typedef enum logic [1:0] {
    PIX_ARGB1555 = 2'd0,
    PIX_RGB565   = 2'd1,
    PIX_RGB888   = 2'd2,
    PIX_ARGB8888 = 2'd3
  } pix_fmt_e;

  localparam int MODE_EN_BIT    = 0;
  localparam int MODE_FMT_LSB   = 2;
  localparam int CFG_OUT_BIT    = 0;
  localparam int CFG_ILACE_BIT  = 1;
  localparam int CFG2_BLANK_BIT = 3;
endpackage

// File: rtl/dispfmt_div3.sv
module dispfmt_div3 #(
  parameter int IN_W = 13
) (
  input  logic [IN_W-1:0] x_i,
  output logic [IN_W-1:0] q_o
);
  // floor(x/3) by reciprocal multiply; SH = IN_W+2 keeps it exact over the input range
  localparam int SH = IN_W + 2;
  localparam int PW = IN_W + SH;
  localparam logic [PW-1:0] RECIP = PW'(((64'd1 << SH) + 64'd2) / 64'd3);

  logic [PW-1:0] prod;
  assign prod = PW'(x_i) * RECIP;
  assign q_o  = IN_W'(prod >> SH);
endmodule

// File: rtl/dispfmt_geom.sv
module dispfmt_geom
  import dispfmt_pkg::*;
#(
  parameter int FIELD_W = 10,
  localparam int CNT_W  = FIELD_W + 1,
  localparam int RES_W  = FIELD_W + 2,
  localparam int STR_W  = FIELD_W + 4
) (
  input  logic [31:0]      size_i,
  input  pix_fmt_e         fmt_i,
  input  logic             ilace_i,
  output logic [STR_W-1:0] stride_o,
  output logic [RES_W-1:0] hres_o,
  output logic [RES_W-1:0] vres_o
);
  logic [CNT_W-1:0]   words, lines;
  logic [CNT_W:0]     span;
  logic [CNT_W+1:0]   bytes_w, third;

  assign words   = CNT_W'(size_i[FIELD_W-1:0]) + CNT_W'(1);
  assign lines   = CNT_W'(size_i[2*FIELD_W-1:FIELD_W]) + CNT_W'(1);
  assign span    = (CNT_W+1)'(words) + (CNT_W+1)'(size_i[3*FIELD_W-1:2*FIELD_W]) - (CNT_W+1)'(1);
  assign stride_o = {span, 2'b00};
  assign bytes_w = {words, 2'b00};

  dispfmt_div3 #(.IN_W(CNT_W+2)) u_div3 (.x_i(bytes_w), .q_o(third));

  always_comb begin
    unique case (fmt_i)
      PIX_ARGB1555, PIX_RGB565: hres_o = {words, 1'b0};
      PIX_RGB888:               hres_o = RES_W'(third);
      default:                  hres_o = RES_W'(words);
    endcase
  end

  assign vres_o = ilace_i ? {lines, 1'b0} : {1'b0, lines};
endmodule

// File: rtl/dispfmt_slots.sv
module dispfmt_slots
  import dispfmt_pkg::*;
#(
  parameter int RES_W = 12,
  localparam int N_SLOT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             clr_i,
  input  logic [RES_W-1:0] hres_i,
  input  logic [RES_W-1:0] vres_i,
  input  pix_fmt_e         fmt_i,
  output logic             changed_o
);
  logic             idx_q;
  logic [RES_W-1:0] hres_q [N_SLOT];
  logic [RES_W-1:0] vres_q [N_SLOT];
  pix_fmt_e         fmt_q  [N_SLOT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= 1'b0;
    else if (wr_i)  idx_q <= ~idx_q;
    else if (clr_i) idx_q <= 1'b0;
  end

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hres_q[s] <= '0;
        vres_q[s] <= '0;
        fmt_q[s]  <= PIX_ARGB1555;
      end else if (wr_i && (idx_q == 1'(s))) begin
        hres_q[s] <= hres_i;
        vres_q[s] <= vres_i;
        fmt_q[s]  <= fmt_i;
      end else if (clr_i && (s == 0)) begin
        hres_q[s] <= '0;
        vres_q[s] <= '0;
      end
    end
  end

  assign changed_o = (hres_i != hres_q[~idx_q]) || (vres_i != vres_q[~idx_q]) ||
                     (fmt_i != fmt_q[~idx_q]);
endmodule

// File: rtl/dispfmt_decoder.sv
module dispfmt_decoder
  import dispfmt_pkg::*;
#(
  parameter int FIELD_W = 10,
  localparam int RES_W  = FIELD_W + 2,
  localparam int STR_W  = FIELD_W + 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             present_i,
  input  logic [31:0]      size_i,
  input  logic [31:0]      mode_i,
  input  logic [31:0]      cfg_i,
  input  logic [31:0]      cfg2_i,
  input  logic [31:0]      border_i,
  input  logic [31:0]      base_i,
  output logic             done_o,
  output logic             en_o,
  output logic             blank_o,
  output logic [31:0]      fill_o,
  output logic             fmt_changed_o,
  output logic [1:0]       fmt_o,
  output logic [RES_W-1:0] hres_o,
  output logic [RES_W-1:0] vres_o,
  output logic [STR_W-1:0] stride_o,
  output logic [31:0]      base_o
);
  pix_fmt_e         fmt_in;
  logic             en_in;
  logic [STR_W-1:0] stride_c;
  logic [RES_W-1:0] hres_c, vres_c;
  logic             changed_c;

  assign fmt_in = pix_fmt_e'(mode_i[MODE_FMT_LSB +: 2]);
  assign en_in  = mode_i[MODE_EN_BIT] & cfg_i[CFG_OUT_BIT];

  dispfmt_geom #(.FIELD_W(FIELD_W)) u_geom (
    .size_i  (size_i),
    .fmt_i   (fmt_in),
    .ilace_i (cfg_i[CFG_ILACE_BIT]),
    .stride_o(stride_c),
    .hres_o  (hres_c),
    .vres_o  (vres_c)
  );

  dispfmt_slots #(.RES_W(RES_W)) u_slots (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (present_i & en_in),
    .clr_i    (present_i & ~en_in),
    .hres_i   (hres_c),
    .vres_i   (vres_c),
    .fmt_i    (fmt_in),
    .changed_o(changed_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o        <= 1'b0;
      en_o          <= 1'b0;
      blank_o       <= 1'b0;
      fill_o        <= '0;
      fmt_changed_o <= 1'b0;
      fmt_o         <= '0;
      hres_o        <= '0;
      vres_o        <= '0;
      stride_o      <= '0;
      base_o        <= '0;
    end else begin
      done_o <= present_i;
      if (present_i) begin
        en_o <= en_in;
        if (en_in) begin
          blank_o       <= cfg2_i[CFG2_BLANK_BIT];
          fill_o        <= border_i;
          fmt_changed_o <= changed_c;
          fmt_o         <= fmt_in;
          hres_o        <= hres_c;
          vres_o        <= vres_c;
          stride_o      <= stride_c;
          base_o        <= base_i;
        end else begin
          blank_o       <= 1'b0;
          fmt_changed_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dispfmt_decoder_chk.sv
module dispfmt_decoder_chk #(
  parameter int FIELD_W = 10,
  localparam int RES_W  = FIELD_W + 2,
  localparam int STR_W  = FIELD_W + 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             present_i,
  input logic [31:0]      mode_i,
  input logic [31:0]      cfg_i,
  input logic             done_o,
  input logic             en_o,
  input logic             blank_o,
  input logic             fmt_changed_o,
  input logic [1:0]       fmt_o,
  input logic [RES_W-1:0] hres_o,
  input logic [RES_W-1:0] vres_o,
  input logic [STR_W-1:0] stride_o,
  input logic [31:0]      base_o
);
  assert_done_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    present_i |=> done_o);
  assert_done_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !present_i |=> !done_o);
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !present_i |=> ($stable(hres_o) && $stable(vres_o) && $stable(stride_o) &&
                    $stable(fmt_o) && $stable(base_o) && $stable(en_o)));
  assert_enable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    present_i |=> (en_o == ($past(mode_i[0]) && $past(cfg_i[0]))));
  assert_interlace_even_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (present_i && mode_i[0] && cfg_i[0] && cfg_i[1]) |=> !vres_o[0]);
  assert_changed_needs_en_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_changed_o |-> en_o);
  assert_blank_needs_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_o |-> en_o);
  assert_disabled_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (present_i && !(mode_i[0] && cfg_i[0])) |=>
      ($stable(hres_o) && $stable(vres_o) && !fmt_changed_o && !blank_o));
endmodule

bind dispfmt_decoder dispfmt_decoder_chk #(.FIELD_W(FIELD_W)) u_chk (.*);

// File: tb/dispfmt_decoder_bench.sv
module dispfmt_decoder_bench;
  logic clk = 1'b0, rst_n = 1'b0, present = 1'b0;
  logic [31:0] size_r = '0, mode_r = '0, cfg_r = '0, cfg2_r = '0, border_r = '0, base_r = '0;
  logic done, en, blank, chg;
  logic [31:0] fill, base;
  logic [1:0] fmt;
  logic [11:0] hres, vres;
  logic [13:0] stride;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  dispfmt_decoder u_dispfmt_decoder (
    .clk_i(clk), .rst_ni(rst_n), .present_i(present), .size_i(size_r), .mode_i(mode_r),
    .cfg_i(cfg_r), .cfg2_i(cfg2_r), .border_i(border_r), .base_i(base_r),
    .done_o(done), .en_o(en), .blank_o(blank), .fill_o(fill), .fmt_changed_o(chg),
    .fmt_o(fmt), .hres_o(hres), .vres_o(vres), .stride_o(stride), .base_o(base));

  // behavioural model
  int e_done, e_en, e_blank, e_fill, e_chg, e_fmt, e_hres, e_vres, e_stride, e_base;
  int sh[2], sv[2], sf[2];
  int idx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_done = 0; e_en = 0; e_blank = 0; e_fill = 0; e_chg = 0; e_fmt = 0;
      e_hres = 0; e_vres = 0; e_stride = 0; e_base = 0; idx = 0;
      sh = '{0, 0}; sv = '{0, 0}; sf = '{0, 0};
    end else begin
      e_done = present;
      if (present) begin
        int w, l, m, f, h, v;
        w = int'(size_r[9:0]) + 1; l = int'(size_r[19:10]) + 1; m = int'(size_r[29:20]);
        f = int'(mode_r[3:2]);
        case (f)
          0, 1: h = w * 2;
          2: h = (w * 4) / 3;
          default: h = w;
        endcase
        v = cfg_r[1] ? l * 2 : l;
        e_en = (mode_r[0] && cfg_r[0]) ? 1 : 0;
        if (e_en == 1) begin
          e_chg = (h != sh[1-idx] || v != sv[1-idx] || f != sf[1-idx]) ? 1 : 0;
          sh[idx] = h; sv[idx] = v; sf[idx] = f; idx = 1 - idx;
          e_blank = int'(cfg2_r[3]); e_fill = int'(border_r); e_base = int'(base_r);
          e_fmt = f; e_hres = h; e_vres = v; e_stride = (w + m - 1) * 4;
        end else begin
          e_chg = 0; e_blank = 0; idx = 0; sh[0] = 0; sv[0] = 0;
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 stride", int'(stride), e_stride);
      chk("R3 enable", int'(en), e_en);
      chk("R4 vres", int'(vres), e_vres);
      chk("R5 hres", int'(hres), e_hres);
      chk("R5 fmt", int'(fmt), e_fmt);
      chk("R6 done", int'(done), e_done);
      chk("R7 changed", int'(chg), e_chg);
      chk("R9 blank", int'(blank), e_blank);
      chk("R9 fill", int'(fill), e_fill);
      chk("R9 base", int'(base), e_base);
    end
  end

  function automatic logic [31:0] mk_size(int md, int lm1, int wm1);
    return {2'b00, 10'(md), 10'(lm1), 10'(wm1)};
  endfunction

  task automatic pres(logic [31:0] s, int f, bit ena, bit vo, bit il, bit blk, int gap);
    @(negedge clk);
    size_r = s; mode_r = {28'd0, 2'(f), 1'b0, ena}; cfg_r = {30'd0, il, vo};
    cfg2_r = {28'd0, blk, 3'd0}; border_r = $urandom; base_r = $urandom;
    present = 1'b1;
    @(negedge clk);
    present = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] sa, sb;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1 reset", int'({done, en, blank, chg, fmt}) + int'(hres) + int'(vres) +
        int'(stride) + int'(fill) + int'(base), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'(hres) + int'(en), 0);
    sa = mk_size(5, 479, 319);
    sb = mk_size(0, 239, 1023);
    // R5 each format, R4 interlace, R2 modulo 0 and max words
    pres(sa, 0, 1, 1, 0, 0, 0);
    pres(sa, 1, 1, 1, 1, 0, 2);
    pres(sb, 2, 1, 1, 0, 0, 1);
    pres(sb, 3, 1, 1, 1, 0, 0);
    pres(mk_size(1023, 1023, 1023), 2, 1, 1, 1, 0, 1);
    // R7: change flag appears twice after a format switch, blank at the same present
    pres(sa, 1, 1, 1, 0, 1, 1);
    pres(sa, 1, 1, 1, 0, 1, 1);
    pres(sa, 1, 1, 1, 0, 0, 1);
    pres(sa, 3, 1, 1, 0, 1, 0);
    pres(sa, 3, 1, 1, 0, 0, 0);
    // R8: A@0, B@1, A@0 then disable; B afterwards must match slot 1 only if the pointer reset
    pres(sa, 0, 1, 1, 0, 0, 1);
    pres(sa, 1, 1, 1, 0, 0, 1);
    pres(sa, 0, 1, 1, 0, 0, 1);
    pres(sb, 2, 0, 1, 0, 1, 1);
    @(negedge clk);
    chk("R8 disabled clears change", int'(chg), 0);
    pres(sa, 1, 1, 1, 0, 0, 1);
    @(negedge clk);
    chk("R8 pointer reset compare", int'(chg), 0);
    pres(sb, 2, 1, 0, 0, 1, 1);
    pres(sb, 2, 0, 0, 0, 0, 1);
    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      logic [31:0] s;
      s = ($urandom % 4 == 0) ? mk_size($urandom % 1024, $urandom % 1024, $urandom % 1024) :
          (($urandom % 2) ? sa : sb);
      pres(s, $urandom % 4, ($urandom % 6) != 0, ($urandom % 6) != 0, 1'($urandom),
           1'($urandom), $urandom % 3);
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule